// File: doc/BRIEF.md
# Colour Lookup Register Interface

This block holds a colour lookup table of 256 main entries and four overlay entries, each a red, green and blue byte, and exposes it to a processor through a small window of 32-bit registers. Software first writes an index register. It then streams colour components through a colour register, red first, then green, then blue. After each blue component the index moves on by one, so a whole palette can be loaded with a single index write followed by a run of colour writes.

Every byte that matters on the bus travels in bits 31:24 of the word. A second colour offset steers writes into the overlay entries, which the cursor logic uses. Only the two low bits of the index select among those four entries. The display pipeline has its own combinational lookup port, so it can fetch any entry as a 24-bit colour while the bus is updating the table.

Top module: `clut_regs`

## Requirements
- R1: A full-word write to byte offset 0 loads the index from bits 31:24 and returns the component phase to red, even in the middle of a triplet.
- R2: Full-word colour writes at offset 4 go to main entry [index]. Those at offset 12 go to overlay entry 256 + index[1:0]. The index still advances after the blue write of an overlay triplet.
- R3: Successive colour accesses take red, then green, then blue. After blue the phase returns to red and the index increments modulo 256, so 255 is followed by 0.
- R4: A full-word read at offset 4 or 12 returns the current component of main entry [index] in bits 31:24, with bits 23:0 zero. It advances the phase and the index exactly as a write does.
- R5: After reset, entries 255, 256 and 258 are white (all components 0xFF) and every other entry is black. The index is 0 and the phase is red.
- R6: Accesses at any offset other than 0, 4 and 12 leave the table, the index and the phase unchanged, and reads there return 0.
- R7: An access whose byte enables are not all set is ignored in the same way, and a read of that kind returns 0.
- R8: The lookup port maps a 9-bit entry number combinationally to {red[23:16], green[15:8], blue[7:0]}. Entry numbers above 259 give 0. A bus write is visible there from the cycle after its clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_req | input | 1 | Access strobe, one access per cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Byte offset within the register window |
| bus_be | input | 4 | Byte enables; all four must be set |
| bus_wdata | input | 32 | Write data, byte in 31:24 |
| bus_rdata | output | 32 | Read data, valid in the cycle of the read strobe |
| lut_idx | input | 9 | Entry number for the display lookup |
| lut_rgb | output | 24 | Colour of that entry |

## Verification
The hardest state to reach from the ports is a sequencer that sits in the middle of a triplet while something else happens to it. Examples are an index reload, an ignored narrow or off-window access, or a read that mixes offsets 4 and 12. The stimulus gets there by writing or reading a partial triplet and then injecting the disturbing access. It then completes a triplet and reads the entry through the lookup port, so that where each byte landed shows the phase and index that survived. The overlay alias and the 255-to-0 wrap are reached by loading indices 6 and 255 directly.

// File: rtl/clut_pkg.sv
package clut_pkg;
  typedef enum logic [1:0] {
    PH_RED = 2'd0,
    PH_GRN = 2'd1,
    PH_BLU = 2'd2
  } phase_e;

  localparam logic [3:0] OFS_INDEX = 4'h0;
  localparam logic [3:0] OFS_MAIN  = 4'h4;
  localparam logic [3:0] OFS_OVL   = 4'hC;
endpackage

// File: rtl/clut_decode.sv
module clut_decode
  import clut_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int BE_W   = 4
) (
  input  logic              req,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BE_W-1:0]   be,
  output logic              idx_load,
  output logic              col_wr,
  output logic              col_rd,
  output logic              col_ovl
);
  logic full_word;
  logic at_index;
  logic at_colour;

  always_comb begin
    full_word = &be;
    at_index  = (addr == ADDR_W'(OFS_INDEX));
    col_ovl   = (addr == ADDR_W'(OFS_OVL));
    at_colour = (addr == ADDR_W'(OFS_MAIN)) || col_ovl;
    idx_load  = req && we && full_word && at_index;
    col_wr    = req && we && full_word && at_colour;
    col_rd    = req && !we && full_word && at_colour;
  end
endmodule

// File: rtl/clut_seq.sv
module clut_seq
  import clut_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             idx_load,
  input  logic [IDX_W-1:0] idx_val,
  input  logic             col_step,
  output logic [IDX_W-1:0] idx_q,
  output phase_e           phase_q
);
  logic [IDX_W-1:0] idx_d;
  phase_e           phase_d;
  logic             upd_en;

  always_comb begin
    idx_d   = idx_q;
    phase_d = phase_q;
    upd_en  = idx_load || col_step;
    if (idx_load) begin
      idx_d   = idx_val;
      phase_d = PH_RED;
    end else if (col_step) begin
      case (phase_q)
        PH_RED:  phase_d = PH_GRN;
        PH_GRN:  phase_d = PH_BLU;
        default: begin
          phase_d = PH_RED;
          idx_d   = idx_q + 1'b1;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q   <= '0;
      phase_q <= PH_RED;
    end else if (upd_en) begin
      idx_q   <= idx_d;
      phase_q <= phase_d;
    end
  end

  p_index_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
    idx_load |=> (idx_q == $past(idx_val)) && (phase_q == PH_RED));

  p_blue_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (col_step && !idx_load && phase_q == PH_BLU) |=>
      (phase_q == PH_RED) && (idx_q == $past(idx_q) + 1'b1));

  p_phase_legal_r3: assert property (@(posedge clk) disable iff (!rst_n)
    phase_q != 2'd3);
endmodule

// File: rtl/clut_store.sv
module clut_store
  import clut_pkg::*;
#(
  parameter int CH_W   = 8,
  parameter int MAIN_N = 256,
  parameter int OVL_N  = 4,
  localparam int ENT_N = MAIN_N + OVL_N,
  localparam int ENT_W = $clog2(ENT_N),
  localparam int IDX_W = $clog2(MAIN_N),
  localparam int RGB_W = 3 * CH_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [ENT_W-1:0] wr_entry,
  input  phase_e           wr_ch,
  input  logic [CH_W-1:0]  wr_byte,
  input  logic [IDX_W-1:0] bus_ridx,
  input  phase_e           bus_rch,
  output logic [CH_W-1:0]  bus_rbyte,
  input  logic [ENT_W-1:0] lut_idx,
  output logic [RGB_W-1:0] lut_rgb
);
  logic [RGB_W-1:0] ents [ENT_N];

  for (genvar e = 0; e < ENT_N; e++) begin : g_ent
    localparam bit IS_WHITE = (e == MAIN_N - 1) || (e == MAIN_N) || (e == MAIN_N + 2);
    localparam logic [RGB_W-1:0] RST_VAL = IS_WHITE ? {RGB_W{1'b1}} : {RGB_W{1'b0}};
    logic [RGB_W-1:0] ent_q;
    logic [RGB_W-1:0] ent_d;
    logic             hit;

    always_comb begin
      hit   = wr_en && (wr_entry == ENT_W'(e));
      ent_d = ent_q;
      case (wr_ch)
        PH_RED:  ent_d[RGB_W-1 -: CH_W]  = wr_byte;
        PH_GRN:  ent_d[2*CH_W-1 -: CH_W] = wr_byte;
        default: ent_d[CH_W-1:0]         = wr_byte;
      endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ent_q <= RST_VAL;
      else if (hit) ent_q <= ent_d;
    end

    assign ents[e] = ent_q;
  end

  logic [RGB_W-1:0] bus_ent;

  always_comb begin
    bus_ent = ents[ENT_W'(bus_ridx)];
    case (bus_rch)
      PH_RED:  bus_rbyte = bus_ent[RGB_W-1 -: CH_W];
      PH_GRN:  bus_rbyte = bus_ent[2*CH_W-1 -: CH_W];
      default: bus_rbyte = bus_ent[CH_W-1:0];
    endcase
    if (lut_idx < ENT_W'(ENT_N)) lut_rgb = ents[lut_idx];
    else lut_rgb = '0;
  end

  p_entry_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (wr_entry < ENT_W'(ENT_N)));
endmodule

// File: rtl/clut_regs.sv
module clut_regs
  import clut_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4,
  parameter int CH_W   = 8,
  parameter int MAIN_N = 256,
  parameter int OVL_N  = 4,
  localparam int BE_W  = DATA_W / 8,
  localparam int ENT_W = $clog2(MAIN_N + OVL_N),
  localparam int IDX_W = $clog2(MAIN_N),
  localparam int OVL_W = $clog2(OVL_N),
  localparam int RGB_W = 3 * CH_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_req,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BE_W-1:0]   bus_be,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [ENT_W-1:0]  lut_idx,
  output logic [RGB_W-1:0]  lut_rgb
);
  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  logic idx_load, col_wr, col_rd, col_ovl;

  clut_decode #(.ADDR_W(ADDR_W), .BE_W(BE_W)) u_dec (
    .req(bus_req), .we(bus_we), .addr(bus_addr), .be(bus_be),
    .idx_load(idx_load), .col_wr(col_wr), .col_rd(col_rd), .col_ovl(col_ovl)
  );

  logic [CH_W-1:0]  bus_byte;
  logic [IDX_W-1:0] idx_q;
  phase_e           phase_q;
  logic             unused_wdata_lo;

  assign bus_byte        = bus_wdata[DATA_W-1 -: CH_W];
  assign unused_wdata_lo = ^bus_wdata[DATA_W-CH_W-1:0];

  clut_seq #(.IDX_W(IDX_W)) u_seq (
    .clk(clk), .rst_n(rst_sync_n),
    .idx_load(idx_load), .idx_val(bus_byte[IDX_W-1:0]),
    .col_step(col_wr || col_rd),
    .idx_q(idx_q), .phase_q(phase_q)
  );

  logic [ENT_W-1:0] wr_entry;
  logic [CH_W-1:0]  rd_byte;

  always_comb begin
    if (col_ovl) wr_entry = ENT_W'(MAIN_N) + ENT_W'(idx_q[OVL_W-1:0]);
    else wr_entry = ENT_W'(idx_q);
    if (col_rd) bus_rdata = {rd_byte, {(DATA_W-CH_W){1'b0}}};
    else bus_rdata = '0;
  end

  clut_store #(.CH_W(CH_W), .MAIN_N(MAIN_N), .OVL_N(OVL_N)) u_store (
    .clk(clk), .rst_n(rst_sync_n),
    .wr_en(col_wr), .wr_entry(wr_entry), .wr_ch(phase_q), .wr_byte(bus_byte),
    .bus_ridx(idx_q), .bus_rch(phase_q), .bus_rbyte(rd_byte),
    .lut_idx(lut_idx), .lut_rgb(lut_rgb)
  );

  p_off_window_r6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bus_req && (&bus_be) && bus_addr != ADDR_W'(OFS_INDEX) &&
     bus_addr != ADDR_W'(OFS_MAIN) && bus_addr != ADDR_W'(OFS_OVL))
      |=> $stable(idx_q) && $stable(phase_q));

  p_narrow_ignored_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bus_req && !(&bus_be)) |=> $stable(idx_q) && $stable(phase_q));

  p_narrow_rdata_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bus_req && !(&bus_be)) |-> (bus_rdata == '0));

  p_read_low_zero_r4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bus_req && !bus_we) |-> (bus_rdata[DATA_W-CH_W-1:0] == '0));
endmodule

// File: tb/sim_clut_regs.sv
module sim_clut_regs;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_req, bus_we;
  logic [3:0]  bus_addr, bus_be;
  logic [31:0] bus_wdata, bus_rdata;
  logic [8:0]  lut_idx;
  logic [23:0] lut_rgb;

  int vectors = 0;
  int errors  = 0;
  bit done    = 1'b0;

  always #10 clk = ~clk;

  clut_regs u0 (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .lut_idx(lut_idx), .lut_rgb(lut_rgb)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d, input logic [3:0] be = 4'hF);
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d; bus_be = be;
    @(negedge clk);
    bus_req = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d, input logic [3:0] be = 4'hF);
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b0; bus_addr = a; bus_be = be;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_req = 1'b0;
  endtask

  task automatic look(input string tag, input int e, input logic [23:0] exp);
    lut_idx = 9'(e);
    #1 check(tag, {8'h0, lut_rgb}, {8'h0, exp});
  endtask

  task automatic t_reset();
    look("R5 entry0 black", 0, 24'h000000);
    look("R5 entry254 black", 254, 24'h000000);
    look("R5 entry255 white", 255, 24'hFFFFFF);
    look("R5 entry256 white", 256, 24'hFFFFFF);
    look("R5 entry257 black", 257, 24'h000000);
    look("R5 entry258 white", 258, 24'hFFFFFF);
    look("R5 entry259 black", 259, 24'h000000);
    look("R8 entry260 zero", 260, 24'h000000);
    look("R8 entry511 zero", 511, 24'h000000);
    wr(4'h4, 32'h9900_0000);
    look("R5 index0 phase red", 0, 24'h990000);
  endtask

  task automatic t_triplet();
    wr(4'h0, 32'h0A00_0000);
    wr(4'h4, 32'h1100_0000);
    look("R8 red visible next cycle", 10, 24'h110000);
    wr(4'h4, 32'h2200_0000);
    wr(4'h4, 32'h3300_0000);
    look("R3 rgb order", 10, 24'h112233);
    look("R3 neighbour untouched", 11, 24'h000000);
    wr(4'h4, 32'h4400_0000);
    look("R3 index increments", 11, 24'h440000);
  endtask

  task automatic t_wrap();
    wr(4'h0, 32'hFF00_0000);
    wr(4'h4, 32'hA100_0000);
    wr(4'h4, 32'hA200_0000);
    wr(4'h4, 32'hA300_0000);
    look("R3 entry255 written", 255, 24'hA1A2A3);
    wr(4'h4, 32'hB100_0000);
    look("R3 wrap 255 to 0", 0, 24'hB10000);
    look("R3 no spill to 256", 256, 24'hFFFFFF);
  endtask

  task automatic t_overlay();
    wr(4'h0, 32'h0600_0000);
    wr(4'hC, 32'h0100_0000);
    wr(4'hC, 32'h0200_0000);
    wr(4'hC, 32'h0300_0000);
    look("R2 overlay alias 258", 258, 24'h010203);
    look("R2 main entry6 untouched", 6, 24'h000000);
    wr(4'hC, 32'h7700_0000);
    look("R2 overlay index advanced to 259", 259, 24'h770000);
  endtask

  task automatic t_read();
    logic [31:0] d;
    wr(4'h0, 32'h0A00_0000);
    rd(4'h4, d); check("R4 read red", d, 32'h1100_0000);
    rd(4'h4, d); check("R4 read green", d, 32'h2200_0000);
    rd(4'hC, d); check("R4 read blue at offset 12", d, 32'h3300_0000);
    rd(4'hC, d); check("R4 read advanced to entry11 main", d, 32'h4400_0000);
    rd(4'h4, d); check("R4 read green entry11", d, 32'h0000_0000);
    wr(4'h4, 32'h5A00_0000);
    look("R4 read shares phase with write", 11, 24'h44005A);
  endtask

  task automatic t_midload();
    wr(4'h0, 32'h1400_0000);
    wr(4'h4, 32'hAA00_0000);
    wr(4'h0, 32'h1400_0000);
    wr(4'h4, 32'hBB00_0000);
    wr(4'h4, 32'hCC00_0000);
    wr(4'h4, 32'hDD00_0000);
    look("R1 reload restarts at red", 20, 24'hBBCCDD);
  endtask

  task automatic t_ignore();
    logic [31:0] d;
    wr(4'h0, 32'h1E00_0000);
    wr(4'h8, 32'hEE00_0000);
    wr(4'h5, 32'hEE00_0000);
    wr(4'h0, 32'h0500_0000, 4'h8);
    wr(4'h4, 32'h6600_0000, 4'h7);
    rd(4'h8, d); check("R6 off-window read zero", d, 32'h0);
    rd(4'h4, d, 4'hE); check("R7 narrow read zero", d, 32'h0);
    look("R7 entry30 unchanged", 30, 24'h000000);
    look("R7 entry5 unchanged", 5, 24'h000000);
    wr(4'h4, 32'h5500_0000);
    look("R6 index and phase kept", 30, 24'h550000);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog R1..R8 actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; bus_req = 1'b0; bus_we = 1'b0; bus_addr = '0;
    bus_be = '0; bus_wdata = '0; lut_idx = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_triplet();
    t_wrap();
    t_overlay();
    t_read();
    t_midload();
    t_ignore();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule